// File: doc/BRIEF.md
# NAND Column Pointer Command Decoder

This block models the command front end of a small-page, byte-wide NAND flash, seen from the device side. It samples the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins and the 8-bit I/O bus on a system clock. It decodes the latched commands and keeps a column pointer that selects one of three regions of a 528-byte page: the lower half, the upper half, or the 16-byte spare area. It counts the address cycles of a read and reports the absolute start column and the row. It also answers the identification read with fixed maker and device bytes.

The block takes the place of a memory model in controller testbenches. The array, the page register storage and the program and erase operations live elsewhere. A one-cycle read-enable pulse tells that data path when to move the next byte of an array read.

Top module: `nand_col_ptr_front`

## Requirements
- R1: After reset the pointer selects the lower-half region, identification mode is off, and `start_col_o`, `row_o`, `dout_o`, `rd_en_o` and `addr_done_o` are all zero.
- R2: A command or address byte is taken only at a rising edge of `we_ni` while `ce_ni` is low. It is a command when `cle_i`=1 and `ale_i`=0, and an address when `ale_i`=1 and `cle_i`=0. A write strobe with `ce_ni` high, or with both latch pins high, changes nothing.
- R3: Command 00h selects the lower half (base 0), 01h the upper half (base 256) and 50h the spare area (base 512). The start column is the region base plus the first address byte, so any column from 0 to 527 can be reached.
- R4: In the spare region only bits 3:0 of the first address byte count. Bits 7:4 are ignored, so the start column stays within 512..527.
- R5: A read address has three cycles: the column byte, then row bits 7:0, then row bits 15:8. One cycle after the third address strobe, `addr_done_o` pulses for one clock and `start_col_o` and `row_o` take their new values. The next address strobe starts a new sequence, and any command restarts the count.
- R6: The 01h selection covers a single address sequence. Once that sequence completes, the pointer returns to the lower half. The 00h and 50h selections stay in force across any number of address sequences without a new command.
- R7: Command 90h followed by one address cycle of 00h enters identification mode. Any other byte in that address cycle leaves the mode off.
- R8: In identification mode, successive read strobes (`re_ni` falling while `ce_ni` is low) put ECh, then 75h, then 00h for every further read on `dout_o`, one clock after the strobe. Entering the mode again restarts the sequence at ECh.
- R9: Identification mode lasts until any command is written. A command other than 00h, 01h or 50h leaves the pointer region unchanged.
- R10: Outside identification mode, once an address sequence has completed, each read strobe gives a one-clock `rd_en_o` pulse and `dout_o`=00h. Reads in identification mode, reads before the address completes, and read strobes with `ce_ni` high give no pulse and leave `dout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, captured on rising edge |
| re_ni | input | 1 | Read strobe, acts on falling edge |
| io_i | input | 8 | Command, address or data byte in |
| dout_o | output | 8 | Byte returned for a read strobe |
| rd_en_o | output | 1 | One-clock pulse per array read strobe |
| start_col_o | output | 10 | Absolute start column of the last read address |
| row_o | output | 16 | Row of the last read address |
| addr_done_o | output | 1 | Pulse when an address sequence completes |

## Verification
Directed sequences cover each pointer command at the edges of its region: first byte 00h and FFh in the halves, and 0Fh and F3h in the spare area, where masked upper bits must not move the column. Back-to-back address sequences without a new command separate the persistent selections from the one-shot upper-half selection. Identification entry with a zero and a non-zero address byte, reads beyond the two code bytes, and exit through an unknown command show whether the mode flag and the pointer are independent. Random runs mix commands, address bytes, reads and deselected strobes against a bench model, so they exercise mid-sequence commands and reads before an address completes.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {
    PTR_LO    = 2'd0,
    PTR_HI    = 2'd1,
    PTR_SPARE = 2'd2
  } ptr_e;

  localparam logic [7:0] OP_PTR_LO    = 8'h00;
  localparam logic [7:0] OP_PTR_HI    = 8'h01;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_IDENT     = 8'h90;

  localparam int unsigned HALF_BYTES  = 256;
  localparam int unsigned MAIN_BYTES  = 512;
  localparam int unsigned SPARE_BYTES = 16;
  localparam int unsigned PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic cle_i,
  input  logic ale_i,
  input  logic we_ni,
  input  logic re_ni,
  output logic cmd_stb_o,
  output logic adr_stb_o,
  output logic rd_stb_o
);
  logic we_q, re_q;
  logic we_rise, re_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      re_q <= re_ni;
    end
  end

  assign we_rise   = ~we_q & we_ni & ~ce_ni;
  assign re_fall   = re_q & ~re_ni & ~ce_ni;
  assign cmd_stb_o = we_rise & cle_i & ~ale_i;
  assign adr_stb_o = we_rise & ale_i & ~cle_i;
  assign rd_stb_o  = re_fall;

  assert_cmd_after_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_o || adr_stb_o) |-> $past(!we_ni));
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_stb_i,
  input  logic              adr_stb_i,
  input  logic [DATA_W-1:0] io_i,
  input  logic              seq_done_i,
  output ptr_e              ptr_o,
  output logic              id_mode_o,
  output logic              id_setup_o,
  output logic              id_enter_o
);
  ptr_e ptr_q;
  logic id_q, setup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= PTR_LO;
      id_q    <= 1'b0;
      setup_q <= 1'b0;
    end else if (cmd_stb_i) begin
      id_q    <= 1'b0;
      setup_q <= (io_i[7:0] == OP_IDENT);
      case (io_i[7:0])
        OP_PTR_LO:    ptr_q <= PTR_LO;
        OP_PTR_HI:    ptr_q <= PTR_HI;
        OP_PTR_SPARE: ptr_q <= PTR_SPARE;
        default:      ptr_q <= ptr_q;
      endcase
    end else begin
      if (adr_stb_i && setup_q) begin
        setup_q <= 1'b0;
        if (io_i == '0) id_q <= 1'b1;
      end
      // upper-half selection is one-shot
      if (seq_done_i && ptr_q == PTR_HI) ptr_q <= PTR_LO;
    end
  end

  assign ptr_o      = ptr_q;
  assign id_mode_o  = id_q;
  assign id_setup_o = setup_q;
  assign id_enter_o = adr_stb_i & setup_q & (io_i == '0) & ~cmd_stb_i;

  assert_id_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && !cmd_stb_i) |=> id_mode_o);
  assert_id_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(adr_stb_i && io_i == '0));
  assert_hi_oneshot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done_i && ptr_o == PTR_HI && !cmd_stb_i) |=> ptr_o == PTR_LO);
endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect
  import nand_fe_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned ADDR_CYC = 3,
  localparam int unsigned ROW_W   = DATA_W * (ADDR_CYC - 1),
  localparam int unsigned CNT_W   = $clog2(ADDR_CYC),
  localparam int unsigned SPARE_W = $clog2(SPARE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_stb_i,
  input  logic              adr_stb_i,
  input  logic              count_en_i,
  input  logic [DATA_W-1:0] io_i,
  input  ptr_e              ptr_i,
  output logic [COL_W-1:0]  start_col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              done_o,
  output logic              armed_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_CYC - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] col_q;
  logic [ROW_W-1:0]  row_acc, row_nxt;
  logic [COL_W-1:0]  col_eff;

  always_comb begin
    row_nxt = row_acc;
    for (int k = 1; k < ADDR_CYC; k++) begin
      if (cnt_q == CNT_W'(k)) row_nxt[DATA_W*(k-1) +: DATA_W] = io_i;
    end
  end

  always_comb begin
    case (ptr_i)
      PTR_HI:    col_eff = COL_W'(HALF_BYTES) + COL_W'(col_q);
      PTR_SPARE: col_eff = COL_W'(MAIN_BYTES) + COL_W'(col_q[SPARE_W-1:0]);
      default:   col_eff = COL_W'(col_q);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      col_q       <= '0;
      row_acc     <= '0;
      start_col_o <= '0;
      row_o       <= '0;
      done_o      <= 1'b0;
      armed_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (cmd_stb_i) begin
        cnt_q   <= '0;
        armed_o <= 1'b0;
      end else if (adr_stb_i && count_en_i) begin
        row_acc <= row_nxt;
        if (cnt_q == '0) begin
          col_q   <= io_i;
          armed_o <= 1'b0;
        end
        if (cnt_q == LAST) begin
          cnt_q       <= '0;
          done_o      <= 1'b1;
          armed_o     <= 1'b1;
          start_col_o <= col_eff;
          row_o       <= row_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_col_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (start_col_o < COL_W'(PAGE_BYTES)));
  assert_spare_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ptr_i == PTR_SPARE)) |-> (start_col_o >= COL_W'(MAIN_BYTES)));
  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_armed_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> done_o);
endmodule

// File: rtl/nand_read_port.sv
module nand_read_port #(
  parameter int unsigned DATA_W      = 8,
  parameter logic [7:0]  MAKER_CODE  = 8'hEC,
  parameter logic [7:0]  DEVICE_CODE = 8'h75
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stb_i,
  input  logic              id_mode_i,
  input  logic              id_enter_i,
  input  logic              armed_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              rd_en_o
);
  logic [1:0]        idx_q;
  logic [DATA_W-1:0] id_byte;

  always_comb begin
    case (idx_q)
      2'd0:    id_byte = DATA_W'(MAKER_CODE);
      2'd1:    id_byte = DATA_W'(DEVICE_CODE);
      default: id_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      dout_o  <= '0;
      rd_en_o <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      if (id_enter_i) begin
        idx_q <= '0;
      end else if (rd_stb_i) begin
        if (id_mode_i) begin
          dout_o <= id_byte;
          if (idx_q != 2'd2) idx_q <= idx_q + 1'b1;
        end else if (armed_i) begin
          rd_en_o <= 1'b1;
          dout_o  <= '0;
        end
      end
    end
  end

  assert_no_rden_in_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> $past(!id_mode_i && armed_i));
  assert_rden_from_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> $past(rd_stb_i));
endmodule

// File: rtl/nand_col_ptr_front.sv
module nand_col_ptr_front
  import nand_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned COL_W       = 10,
  parameter int unsigned ADDR_CYC    = 3,
  parameter logic [7:0]  MAKER_CODE  = 8'hEC,
  parameter logic [7:0]  DEVICE_CODE = 8'h75,
  localparam int unsigned ROW_W      = DATA_W * (ADDR_CYC - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic              we_ni,
  input  logic              re_ni,
  input  logic [DATA_W-1:0] io_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              rd_en_o,
  output logic [COL_W-1:0]  start_col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              addr_done_o
);
  logic cmd_stb, adr_stb, rd_stb;
  logic id_mode, id_setup, id_enter, armed;
  ptr_e ptr;

  nand_strobe_edge u_edge (
    .clk_i, .rst_ni, .ce_ni, .cle_i, .ale_i, .we_ni, .re_ni,
    .cmd_stb_o(cmd_stb), .adr_stb_o(adr_stb), .rd_stb_o(rd_stb)
  );

  nand_cmd_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk_i, .rst_ni,
    .cmd_stb_i(cmd_stb), .adr_stb_i(adr_stb), .io_i,
    .seq_done_i(addr_done_o),
    .ptr_o(ptr), .id_mode_o(id_mode), .id_setup_o(id_setup), .id_enter_o(id_enter)
  );

  nand_addr_collect #(.DATA_W(DATA_W), .COL_W(COL_W), .ADDR_CYC(ADDR_CYC)) u_adr (
    .clk_i, .rst_ni,
    .cmd_stb_i(cmd_stb), .adr_stb_i(adr_stb),
    .count_en_i(~id_mode & ~id_setup), .io_i, .ptr_i(ptr),
    .start_col_o, .row_o, .done_o(addr_done_o), .armed_o(armed)
  );

  nand_read_port #(.DATA_W(DATA_W), .MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)) u_rd (
    .clk_i, .rst_ni,
    .rd_stb_i(rd_stb), .id_mode_i(id_mode), .id_enter_i(id_enter), .armed_i(armed),
    .dout_o, .rd_en_o
  );
endmodule

// File: tb/tb_nand_col_ptr_front.sv
module tb_nand_col_ptr_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0]  io = 8'h00;
  logic [7:0]  dout;
  logic        rd_en, addr_done;
  logic [9:0]  start_col;
  logic [15:0] row;

  int total = 0, bad = 0;

  // bench model
  int        m_ptr = 0;
  bit        m_id = 0, m_setup = 0, m_armed = 0;
  int        m_cnt = 0, m_idx = 0;
  logic [7:0]  m_col = 0, m_dout = 0;
  logic [15:0] m_row = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_col_ptr_front dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .io_i(io),
    .dout_o(dout), .rd_en_o(rd_en), .start_col_o(start_col), .row_o(row),
    .addr_done_o(addr_done)
  );

  function automatic int exp_col(int p, logic [7:0] a);
    if (p == 1) return 256 + int'(a);
    if (p == 2) return 512 + int'(a & 8'h0F);
    return int'(a);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(bit c, bit a, bit ce_hi, logic [7:0] d, string req);
    bit valid, exp_done;
    int exp_sc;
    @(negedge clk);
    ce_n = ce_hi; cle = c; ale = a; io = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    valid = !ce_hi && (c ^ a);
    exp_done = 0;
    exp_sc = 0;
    if (valid && c) begin
      m_cnt = 0; m_armed = 0; m_id = 0; m_setup = (d == 8'h90);
      if (d == 8'h00) m_ptr = 0;
      else if (d == 8'h01) m_ptr = 1;
      else if (d == 8'h50) m_ptr = 2;
    end else if (valid && a) begin
      if (m_setup) begin
        m_setup = 0;
        if (d == 8'h00) begin m_id = 1; m_idx = 0; end
      end else if (!m_id) begin
        if (m_cnt == 0) begin m_col = d; m_armed = 0; end
        else if (m_cnt == 1) m_row[7:0] = d;
        else begin
          m_row[15:8] = d; exp_done = 1; m_armed = 1;
          exp_sc = exp_col(m_ptr, m_col);
          if (m_ptr == 1) m_ptr = 0;
        end
        m_cnt = (m_cnt + 1) % 3;
      end
    end
    chk({req, " done"}, int'(addr_done), int'(exp_done));
    if (exp_done) begin
      chk({req, " start_col"}, int'(start_col), exp_sc);
      chk({req, " row"}, int'(row), int'(m_row));
    end
    cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
  endtask

  task automatic cmd(logic [7:0] d, string req);  do_write(1, 0, 0, d, req); endtask
  task automatic adr(logic [7:0] d, string req);  do_write(0, 1, 0, d, req); endtask
  task automatic addr3(logic [7:0] c, logic [15:0] r, string req);
    adr(c, req); adr(r[7:0], req); adr(r[15:8], req);
  endtask

  task automatic do_read(bit ce_hi, string req);
    bit exp_en;
    @(negedge clk);
    ce_n = ce_hi; re_n = 1'b0;
    @(negedge clk);
    exp_en = 0;
    if (!ce_hi) begin
      if (m_id) begin
        m_dout = (m_idx == 0) ? 8'hEC : (m_idx == 1) ? 8'h75 : 8'h00;
        if (m_idx < 2) m_idx++;
      end else if (m_armed) begin
        exp_en = 1; m_dout = 8'h00;
      end
    end
    chk({req, " rd_en"}, int'(rd_en), int'(exp_en));
    chk({req, " dout"}, int'(dout), int'(m_dout));
    re_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start_col", int'(start_col), 0);
    chk("R1 row", int'(row), 0);
    chk("R1 dout", int'(dout), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    chk("R1 done", int'(addr_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 default lower region without command; R10 read before address
    do_read(0, "R10 pre-address");
    addr3(8'h12, 16'hA55A, "R1 default ptr");
    do_read(0, "R10 array read");
    // R3 upper half, R6 one-shot fallback
    cmd(8'h01, "R3 cmd01");
    addr3(8'hFF, 16'h0102, "R3 upper max");
    addr3(8'h05, 16'h0304, "R6 fallback");
    // R4 spare masking, R6 persistence
    cmd(8'h50, "R4 cmd50");
    addr3(8'hF3, 16'h1111, "R4 masked");
    addr3(8'h0F, 16'h2222, "R6 spare persists");
    // R5 mid-sequence command restarts count
    adr(8'h33, "R5 partial");
    cmd(8'h00, "R5 restart");
    addr3(8'h00, 16'hBEEF, "R5 full");
    // R2 ignored strobes
    do_write(1, 0, 1, 8'h50, "R2 ce high cmd");
    do_write(1, 1, 0, 8'h01, "R2 both latches");
    addr3(8'h40, 16'h0F0F, "R2 still lower");
    do_read(1, "R10 ce high read");
    // R7/R8 identification
    cmd(8'h50, "R9 set spare");
    cmd(8'h90, "R7 cmd90");
    adr(8'h00, "R7 id addr");
    do_read(0, "R8 maker");
    do_read(0, "R8 device");
    do_read(0, "R8 beyond");
    adr(8'h77, "R9 addr in id");
    do_read(0, "R9 still id");
    cmd(8'hFF, "R9 exit");
    addr3(8'h3C, 16'h4444, "R9 region kept");
    do_read(0, "R10 after exit");
    cmd(8'h90, "R7 cmd90 bad");
    adr(8'h01, "R7 nonzero addr");
    do_read(0, "R7 not id");
    cmd(8'h90, "R8 reenter");
    adr(8'h00, "R8 reenter addr");
    do_read(0, "R8 restart maker");
    cmd(8'h00, "R9 exit 00");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] b;
      op = int'($urandom_range(0, 9));
      b = 8'($urandom);
      case (op)
        0, 1, 2: begin
          int s = int'($urandom_range(0, 5));
          cmd((s == 0) ? 8'h00 : (s == 1) ? 8'h01 : (s == 2) ? 8'h50 :
              (s == 3) ? 8'h90 : (s == 4) ? 8'hFF : 8'h00, "R3 rnd cmd");
        end
        3, 4, 5: adr((m_setup && b[0]) ? 8'h00 : b, "R5 rnd adr");
        6, 7: do_read(0, "R8 rnd read");
        8: do_write(b[0], b[1], 1, b, "R2 rnd deselect");
        default: do_read(b[2], "R10 rnd read");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule